// File: doc/BRIEF.md
# Clock/Data Line Auto-Swap Detector

This block sits behind two single-bit pins of a two-wire serial bus. One pin carries the serial clock and the other carries data, but the board may have them wired either way round. The block samples both lines on a fast internal clock and counts the transitions on each line over an observation window. When the window closes it declares the busier line to be the clock. The choice is then frozen until reset.

After the choice is frozen, a swap multiplexer steers the raw pins onto a dedicated clock output and a dedicated data output. Because the select is a static register by then, the pin-to-output path is purely combinational and does not depend on the sampling clock.

Until the choice is made, both outputs sit at the idle-high level of a pulled-up bus, and any traffic on the lines is thrown away. The sampling clock must run at least four times faster than the line toggle rate. `THRESH` sets the window length in edges, `MARGIN` sets the smallest count gap that is accepted, and `IDLE_LIMIT` sets the quiet time in sampling cycles that discards a partial window.

Top module: `clkdat_autoswap`

## Requirements
- R1: Once locked, with `sel_a_is_clk` = 1, `line_a` drives `clk_out` and `line_b` drives `dat_out`. With `sel_a_is_clk` = 0 the two are swapped.
- R2: While `locked` is 0, both `clk_out` and `dat_out` are held at 1.
- R3: Each line passes through a two-flop synchronizer, and its transitions are counted. The window closes when either count reaches `THRESH` (default 64). If the lock is taken, `locked` rises in the 4th sampling-clock rising edge after the input transition that completes the count, and not earlier.
- R4: When the window closes with a valid gap, `sel_a_is_clk` takes the value 1 if line A has the higher count, and 0 otherwise.
- R5: If the two counts differ by less than `MARGIN` (default 8) when the window closes, both counts clear and a new window starts without locking. A gap of exactly `MARGIN` locks.
- R6: If neither line shows a transition for `IDLE_LIMIT` (default 200) sampling cycles, the partial counts are discarded. The next lock then needs a full `THRESH` fresh transitions.
- R7: Once `locked` is 1, it and `sel_a_is_clk` never change until reset, whatever traffic follows.
- R8: A synchronous active-high `rst` clears `locked` and `sel_a_is_clk` and returns both outputs to 1.
- R9: After lock, the outputs follow the pins combinationally, in the same time step, with no sampling-clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_a | input | 1 | Bus pin A (clock or data) |
| line_b | input | 1 | Bus pin B (clock or data) |
| clk_out | output | 1 | Recovered serial clock, idle high before lock |
| dat_out | output | 1 | Recovered serial data, idle high before lock |
| locked | output | 1 | Routing decision made and frozen |
| sel_a_is_clk | output | 1 | 1 when pin A was judged to be the clock |

## Verification
The lock result is due exactly four sampling edges after the input transition that completes the threshold count. The bench changes pins on falling edges, waits three rising edges and expects `locked` still low, then waits one more rising edge and expects it high. Routed outputs are combinational, so the bench checks them one time unit after each pin change, without waiting for a clock edge. Decisions that must not happen (margin too small, window cut short by idle time) are checked after a settling gap that is longer than the four-cycle latency.

// File: rtl/swap_pkg.sv
package swap_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // one bit per bus pin; a is the upper bit
    typedef struct packed {
        logic a;
        logic b;
    } lines_t;

    typedef enum logic {
        PH_WATCH  = 1'b0,
        PH_FROZEN = 1'b1
    } phase_t;

    function automatic cnt_t count_gap(cnt_t x, cnt_t y);
        return (x > y) ? (x - y) : (y - x);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync
    import swap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t raw,
    output lines_t edge_hit
);
    localparam int NLINES = 2;
    localparam int DEPTH  = 3;

    logic [NLINES-1:0] raw_v;
    logic [NLINES-1:0] hit_v;

    assign raw_v    = raw;
    assign edge_hit = lines_t'(hit_v);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [DEPTH-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) begin
                shreg <= '1;
            end else begin
                shreg <= {shreg[DEPTH-2:0], raw_v[g]};
            end
        end
        // stages 0..1 synchronize, stage 2 holds the previous settled value
        assign hit_v[g] = shreg[DEPTH-1] ^ shreg[DEPTH-2];
    end
endmodule

// File: rtl/edge_stats.sv
module edge_stats
    import swap_pkg::*;
#(
    parameter int THRESH     = 64,
    parameter int MARGIN     = THRESH / 8,
    parameter int IDLE_LIMIT = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t edge_hit,
    output logic   locked,
    output logic   sel_a
);
    localparam int   IDLE_W   = $clog2(IDLE_LIMIT + 1);
    localparam cnt_t THRESH_C = cnt_t'(THRESH);
    localparam cnt_t MARGIN_C = cnt_t'(MARGIN);

    phase_t            phase;
    cnt_t              cnt_a, cnt_b;
    logic [IDLE_W-1:0] idle_cnt;
    logic              window_end;
    logic              gap_ok;
    logic              any_hit;

    assign window_end = (cnt_a >= THRESH_C) || (cnt_b >= THRESH_C);
    assign gap_ok     = count_gap(cnt_a, cnt_b) >= MARGIN_C;
    assign any_hit    = edge_hit.a || edge_hit.b;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_WATCH;
            sel_a    <= 1'b0;
            cnt_a    <= '0;
            cnt_b    <= '0;
            idle_cnt <= '0;
        end else if (phase == PH_WATCH) begin
            if (window_end) begin
                if (gap_ok) begin
                    phase <= PH_FROZEN;
                    sel_a <= (cnt_a > cnt_b);
                end
                cnt_a    <= '0;
                cnt_b    <= '0;
                idle_cnt <= '0;
            end else if (any_hit) begin
                cnt_a    <= cnt_a + cnt_t'(edge_hit.a);
                cnt_b    <= cnt_b + cnt_t'(edge_hit.b);
                idle_cnt <= '0;
            end else if (idle_cnt == IDLE_W'(IDLE_LIMIT - 1)) begin
                cnt_a    <= '0;
                cnt_b    <= '0;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assign locked = (phase == PH_FROZEN);
endmodule

// File: rtl/swap_mux.sv
module swap_mux
    import swap_pkg::*;
(
    input  lines_t raw,
    input  logic   locked,
    input  logic   sel_a,
    output logic   clk_out,
    output logic   dat_out
);
    always_comb begin
        if (!locked) begin
            clk_out = 1'b1;
            dat_out = 1'b1;
        end else if (sel_a) begin
            clk_out = raw.a;
            dat_out = raw.b;
        end else begin
            clk_out = raw.b;
            dat_out = raw.a;
        end
    end
endmodule

// File: rtl/clkdat_autoswap.sv
module clkdat_autoswap
    import swap_pkg::*;
#(
    parameter int THRESH     = 64,
    parameter int MARGIN     = THRESH / 8,
    parameter int IDLE_LIMIT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic line_a,
    input  logic line_b,
    output logic clk_out,
    output logic dat_out,
    output logic locked,
    output logic sel_a_is_clk
);
    lines_t raw;
    lines_t edge_hit;

    assign raw = '{a: line_a, b: line_b};

    line_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw),
        .edge_hit (edge_hit)
    );

    edge_stats #(
        .THRESH     (THRESH),
        .MARGIN     (MARGIN),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_stats (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (edge_hit),
        .locked   (locked),
        .sel_a    (sel_a_is_clk)
    );

    swap_mux u_mux (
        .raw     (raw),
        .locked  (locked),
        .sel_a   (sel_a_is_clk),
        .clk_out (clk_out),
        .dat_out (dat_out)
    );
endmodule

// File: rtl/clkdat_autoswap_chk.sv
module clkdat_autoswap_chk (
    input logic clk,
    input logic rst,
    input logic line_a,
    input logic line_b,
    input logic clk_out,
    input logic dat_out,
    input logic locked,
    input logic sel_a_is_clk
);
    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (clk_out && dat_out));

    // R1
    route_a_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && sel_a_is_clk) |-> (clk_out == line_a && dat_out == line_b));

    // R1
    route_b_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !sel_a_is_clk) |-> (clk_out == line_b && dat_out == line_a));

    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(sel_a_is_clk)));

    // R4
    sel_moves_with_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_a_is_clk) |-> $rose(locked));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!locked && !sel_a_is_clk));
endmodule

bind clkdat_autoswap clkdat_autoswap_chk u_chk (.*);

// File: tb/tb_clkdat_autoswap.sv
module tb_clkdat_autoswap;
    localparam int THRESH = 64;
    localparam int IDLE   = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_q = 1'b1;
    logic b_q = 1'b1;
    logic clk_out, dat_out, locked, sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkdat_autoswap dut (
        .clk          (clk),
        .rst          (rst),
        .line_a       (a_q),
        .line_b       (b_q),
        .clk_out      (clk_out),
        .dat_out      (dat_out),
        .locked       (locked),
        .sel_a_is_clk (sel)
    );

    function automatic logic exp_clk(logic s, logic a, logic b);
        return s ? a : b;
    endfunction

    function automatic logic exp_dat(logic s, logic a, logic b);
        return s ? b : a;
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a_q = 1'b1;
        b_q = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic tog(bit on_a);
        if (on_a) a_q = ~a_q;
        else      b_q = ~b_q;
    endtask

    // last completing transition was driven at a falling edge just before
    task automatic lock_timing(bit exp_sel);
        repeat (3) @(posedge clk);
        #1 check_eq("R3", "locked before latency", locked, 0);
        @(posedge clk);
        #1 check_eq("R3", "locked after latency", locked, 1);
        check_eq("R4", "sel", sel, exp_sel);
    endtask

    task automatic route_checks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            a_q = 1'($urandom);
            b_q = 1'($urandom);
            #1;
            check_eq("R1", "clk_out", clk_out, exp_clk(sel, a_q, b_q));
            check_eq("R9", "dat_out", dat_out, exp_dat(sel, a_q, b_q));
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));

        // R8 reset state
        do_reset();
        #1;
        check_eq("R8", "locked", locked, 0);
        check_eq("R8", "sel", sel, 0);
        check_eq("R8", "clk_out", clk_out, 1);
        check_eq("R8", "dat_out", dat_out, 1);

        // random rounds: clock on a random pin, sparse data
        for (int r = 0; r < 4; r++) begin
            bit on_a;
            int half;
            int n;
            do_reset();
            on_a = 1'($urandom);
            half = 2 + int'($urandom % 4);
            n = 0;
            while (n < THRESH) begin
                repeat (half) @(negedge clk);
                tog(on_a);
                n++;
                if (((on_a ? a_q : b_q) == 1'b0) && ($urandom % 2 == 0))
                    tog(!on_a);
                if (n == 30) begin
                    #1;
                    check_eq("R2", "clk_out idle", clk_out, 1);
                    check_eq("R2", "dat_out idle", dat_out, 1);
                end
            end
            lock_timing(on_a);
            route_checks(8);
            // R7: busy traffic on the data pin must not move the choice
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                tog(!on_a);
            end
            #1;
            check_eq("R7", "locked held", locked, 1);
            check_eq("R7", "sel held", sel, on_a);
            #1 check_eq("R9", "clk_out follows pin", clk_out, exp_clk(sel, a_q, b_q));
        end

        // R5: gap one below the margin, no lock
        do_reset();
        for (int i = 0; i < THRESH; i++) begin
            repeat (3) @(negedge clk);
            tog(1'b1);
            if (i >= 7) tog(1'b0);
        end
        repeat (12) @(negedge clk);
        #1 check_eq("R5", "locked with gap 7", locked, 0);
        check_eq("R5", "clk_out idle", clk_out, 1);

        // R5: gap exactly at the margin locks
        do_reset();
        for (int i = 0; i < THRESH; i++) begin
            repeat (3) @(negedge clk);
            tog(1'b1);
            if (i >= 8) tog(1'b0);
        end
        repeat (12) @(negedge clk);
        #1 check_eq("R5", "locked with gap 8", locked, 1);
        check_eq("R4", "sel with gap 8", sel, 1);

        // R5: equal activity never locks
        do_reset();
        for (int i = 0; i < 300; i++) begin
            repeat (3) @(negedge clk);
            tog(1'b1);
            tog(1'b0);
        end
        repeat (12) @(negedge clk);
        #1 check_eq("R5", "locked equal rates", locked, 0);

        // R6: idle gap discards the partial window; clock on pin b
        do_reset();
        for (int i = 0; i < 40; i++) begin
            repeat (4) @(negedge clk);
            tog(1'b0);
        end
        repeat (IDLE + 50) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            repeat (4) @(negedge clk);
            tog(1'b0);
        end
        repeat (12) @(negedge clk);
        #1 check_eq("R6", "locked after 40 fresh edges", locked, 0);
        for (int i = 0; i < THRESH - 40; i++) begin
            repeat (4) @(negedge clk);
            tog(1'b0);
        end
        lock_timing(1'b0);
        route_checks(6);

        // R8: reset after lock
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_eq("R8", "locked after reset", locked, 0);
        check_eq("R8", "sel after reset", sel, 0);
        check_eq("R8", "clk_out after reset", clk_out, 1);
        check_eq("R8", "dat_out after reset", dat_out, 1);

        finish_run();
    end
endmodule